// File: doc/BRIEF.md
# Frame Byte-to-Word Packer

This block turns an outgoing frame, presented as a byte stream split into segments of any length and alignment, into write accesses to a buffer data port. The port is either 16 bits or 8 bits wide, selected by `word_mode`. In word mode bytes are paired across segment boundaries, so a byte that ends one segment waits for the first byte of the next. A frame shorter than the minimum payload is filled with zeros. At the end of each frame the block reports the frame length after filling.

Bytes enter on a valid/ready handshake. A beat can also carry no byte (`in_nodata`). Such a beat only marks the end of a segment or of the frame, which is how a zero-length segment or an empty frame is expressed. Writes leave as a one-cycle strobe with data and a width flag. A write always appears in the cycle after the beat that completed it. After the frame-end beat the block stalls its input while it flushes a held byte and writes the fill, then pulses `len_valid` with the length.

`word_mode` must stay constant from the first beat of a frame until its `len_valid`.

Top module: `frame_word_packer`

## Requirements
- R1: A frame of fewer than MIN_LEN (60) data bytes is extended with zero bytes so that at least 60 bytes reach the port.
- R2: One cycle after the last write of a frame, `len_valid` is high for one cycle with `len_out` = max(data bytes, 60).
- R3: In word mode every write has `wr_wide`=1. Bytes are paired in stream order regardless of segment boundaries.
- R4: In a word write the earlier byte is in `wr_data[7:0]` and the later byte is in `wr_data[15:8]`.
- R5: In word mode, a byte still held when the frame ends is written with zero in `wr_data[15:8]`.
- R6: In byte mode every data byte and every fill byte is its own write, with `wr_wide`=0, the byte in `wr_data[7:0]` and zero in `wr_data[15:8]`. The write appears in the cycle after the byte is accepted.
- R7: A beat with `in_nodata`=1 produces no write and leaves a held byte intact.
- R8: In word mode the fill is written as zero words. The number of bytes written is max(data bytes rounded up to even, 60).
- R9: From the cycle after the frame-end beat is accepted until the cycle of the final fill or flush decision, `in_ready` is low. The number of low cycles is (flush writes + fill writes + 1).
- R10: A synchronous reset clears the held byte and the length counters. Afterwards `wr_en`=0, `len_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_mode | input | 1 | 1 selects 16-bit port writes, 0 selects 8-bit writes |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | 8 | Input byte |
| in_nodata | input | 1 | Beat carries no byte, only markers |
| in_seg_last | input | 1 | Beat closes a segment |
| in_frame_last | input | 1 | Beat closes the frame |
| wr_en | output | 1 | Port write strobe |
| wr_wide | output | 1 | 1 for a 16-bit write, 0 for an 8-bit write |
| wr_data | output | 16 | Write data, low byte is the lower address |
| len_valid | output | 1 | Frame length report strobe |
| len_out | output | 16 | Frame length after filling |

## Verification
The bench sweeps every frame length from 0 to 70 in both modes. Segment cuts and zero-length segments are placed so that held bytes cross them. A design that dropped or reset the held byte at a segment or marker-only beat would shift every later word by one lane. Swapped lanes would reverse each pair. Odd lengths on both sides of 60 expose a missing flush or a nonzero partner lane. The 59/60/61 boundary catches off-by-one filling, a length report of the written count instead of the data count, and stall windows that are too short or too long. A reset taken while a byte is held shows whether stale state leaks into the next frame.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
   localparam int BYTE_W = 8;
   localparam int LANES  = 2;
   localparam int PORT_W = BYTE_W * LANES;

   typedef enum logic {
      PH_RUN  = 1'b0,
      PH_TAIL = 1'b1
   } phase_t;

   typedef struct packed {
      logic              en;
      logic              wide;
      logic [PORT_W-1:0] data;
   } port_wr_t;
endpackage

// File: rtl/fpk_merge.sv
module fpk_merge
   import fpk_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              word_mode,
   input  logic              take,
   input  logic [BYTE_W-1:0] take_byte,
   input  logic              flush,
   input  logic              pad,
   output logic              hold_v,
   output port_wr_t          emit
);
   logic              hold_q, hold_nxt;
   logic [BYTE_W-1:0] hbyte_q, hbyte_nxt;

   always_comb begin
      emit      = '0;
      hold_nxt  = hold_q;
      hbyte_nxt = hbyte_q;
      if (flush) begin
         emit.en   = 1'b1;
         emit.wide = 1'b1;
         emit.data = {{BYTE_W{1'b0}}, hbyte_q};
         hold_nxt  = 1'b0;
      end else if (pad) begin
         emit.en   = 1'b1;
         emit.wide = word_mode;
      end else if (take) begin
         if (!word_mode) begin
            emit.en   = 1'b1;
            emit.wide = 1'b0;
            emit.data = {{BYTE_W{1'b0}}, take_byte};
         end else if (hold_q) begin
            emit.en   = 1'b1;
            emit.wide = 1'b1;
            emit.data = {take_byte, hbyte_q};
            hold_nxt  = 1'b0;
         end else begin
            hold_nxt  = 1'b1;
            hbyte_nxt = take_byte;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q  <= 1'b0;
         hbyte_q <= '0;
      end else begin
         hold_q  <= hold_nxt;
         hbyte_q <= hbyte_nxt;
      end
   end

   assign hold_v = hold_q;

   // R3
   pair_release_chk: assert property (@(posedge clk) disable iff (rst)
      (take && word_mode && hold_q && !flush && !pad) |=> !hold_q);

   // R5
   flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
      flush |=> !hold_q);

   // R7
   idle_keeps_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!take && !flush && hold_q) |=> (hold_q && $stable(hbyte_q)));
endmodule

// File: rtl/fpk_count.sv
module fpk_count #(
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 60
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             add_byte,
   input  logic             wr_en,
   input  logic             wr_wide,
   output logic [LEN_W-1:0] byte_cnt,
   output logic [LEN_W-1:0] wr_cnt,
   output logic [LEN_W-1:0] len_final,
   output logic             pad_need
);
   localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         byte_cnt <= '0;
         wr_cnt   <= '0;
      end else begin
         if (add_byte) byte_cnt <= byte_cnt + 1'b1;
         if (wr_en)    wr_cnt   <= wr_cnt + (wr_wide ? LEN_W'(2) : LEN_W'(1));
      end
   end

   assign pad_need  = wr_cnt < MIN_V;
   assign len_final = (byte_cnt < MIN_V) ? MIN_V : byte_cnt;

   logic [LEN_W:0] step_end, allow;
   assign step_end = {1'b0, wr_cnt} + (wr_wide ? (LEN_W+1)'(2) : (LEN_W+1)'(1));
   assign allow    = (({1'b0, byte_cnt} + 1'b1) > {1'b0, MIN_V}) ?
                     ({1'b0, byte_cnt} + 1'b1) : {1'b0, MIN_V};

   // R8
   write_bound_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (step_end <= allow));
endmodule

// File: rtl/fpk_tail.sv
module fpk_tail
   import fpk_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic frame_end,
   input  logic word_mode,
   input  logic hold_v,
   input  logic pad_need,
   output logic in_ready,
   output logic flush,
   output logic pad,
   output logic fin
);
   phase_t phase_q;

   always_comb begin
      flush = (phase_q == PH_TAIL) && word_mode && hold_v;
      pad   = (phase_q == PH_TAIL) && !flush && pad_need;
      fin   = (phase_q == PH_TAIL) && !flush && !pad_need;
   end

   assign in_ready = (phase_q == PH_RUN);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_RUN;
      end else begin
         unique case (phase_q)
            PH_RUN:  if (frame_end) phase_q <= PH_TAIL;
            PH_TAIL: if (fin)       phase_q <= PH_RUN;
            default:                phase_q <= PH_RUN;
         endcase
      end
   end

   // R9
   stall_after_end_chk: assert property (@(posedge clk) disable iff (rst)
      frame_end |=> !in_ready);

   // R9
   resume_after_fin_chk: assert property (@(posedge clk) disable iff (rst)
      fin |=> in_ready);
endmodule

// File: rtl/frame_word_packer.sv
module frame_word_packer
   import fpk_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 60
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              word_mode,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_nodata,
   input  logic              in_seg_last,
   input  logic              in_frame_last,
   output logic              wr_en,
   output logic              wr_wide,
   output logic [PORT_W-1:0] wr_data,
   output logic              len_valid,
   output logic [LEN_W-1:0]  len_out
);
   if ((MIN_LEN % LANES) != 0) begin : g_min_len_even
      $error("MIN_LEN must be a multiple of the lane count");
   end
   if (MIN_LEN >= (1 << (LEN_W - 1))) begin : g_len_width
      $error("LEN_W too narrow for MIN_LEN");
   end

   logic     accept, take, frame_end;
   logic     hold_v, flush, pad, fin, pad_need;
   port_wr_t emit;
   logic [LEN_W-1:0] byte_cnt, wr_cnt, len_final;

   assign accept    = in_valid && in_ready;
   assign take      = accept && !in_nodata;
   assign frame_end = accept && in_frame_last;

   fpk_tail u_tail (
      .clk       (clk),
      .rst       (rst),
      .frame_end (frame_end),
      .word_mode (word_mode),
      .hold_v    (hold_v),
      .pad_need  (pad_need),
      .in_ready  (in_ready),
      .flush     (flush),
      .pad       (pad),
      .fin       (fin)
   );

   fpk_merge u_merge (
      .clk       (clk),
      .rst       (rst),
      .word_mode (word_mode),
      .take      (take),
      .take_byte (in_data),
      .flush     (flush),
      .pad       (pad),
      .hold_v    (hold_v),
      .emit      (emit)
   );

   fpk_count #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_count (
      .clk       (clk),
      .rst       (rst),
      .clr       (fin),
      .add_byte  (take),
      .wr_en     (emit.en),
      .wr_wide   (emit.wide),
      .byte_cnt  (byte_cnt),
      .wr_cnt    (wr_cnt),
      .len_final (len_final),
      .pad_need  (pad_need)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_en     <= 1'b0;
         wr_wide   <= 1'b0;
         wr_data   <= '0;
         len_valid <= 1'b0;
         len_out   <= '0;
      end else begin
         wr_en     <= emit.en;
         wr_wide   <= emit.wide;
         wr_data   <= emit.data;
         len_valid <= fin;
         if (fin) len_out <= len_final;
      end
   end

   // R2
   len_floor_chk: assert property (@(posedge clk) disable iff (rst)
      len_valid |-> (len_out >= LEN_W'(MIN_LEN)));

   // R2
   len_after_writes_chk: assert property (@(posedge clk) disable iff (rst)
      len_valid |-> !wr_en);

   // R6
   narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_wide) |-> (wr_data[PORT_W-1:BYTE_W] == '0));

   // R7
   marker_beat_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_nodata) |-> (in_seg_last || in_frame_last));
endmodule

// File: tb/tb_frame_word_packer.sv
`timescale 1ns/1ps
module tb_frame_word_packer;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        word_mode = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic        in_nodata = 1'b0;
   logic        in_seg_last = 1'b0;
   logic        in_frame_last = 1'b0;
   logic        wr_en, wr_wide, len_valid;
   logic [15:0] wr_data, len_out;

   frame_word_packer dut (
      .clk(clk), .rst(rst), .word_mode(word_mode),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_nodata(in_nodata), .in_seg_last(in_seg_last),
      .in_frame_last(in_frame_last), .wr_en(wr_en), .wr_wide(wr_wide),
      .wr_data(wr_data), .len_valid(len_valid), .len_out(len_out)
   );

   always #2 clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   int lg_n = 0;
   int len_seen = 0;
   int busy_n = 0;
   logic [15:0] len_got = '0;
   logic [15:0] lg_d [0:127];
   logic        lg_w [0:127];

   always @(negedge clk) begin
      if (!rst) begin
         if (wr_en) begin
            if (lg_n < 128) begin
               lg_d[lg_n] = wr_data;
               lg_w[lg_n] = wr_wide;
            end
            lg_n = lg_n + 1;
         end
         if (len_valid) begin
            len_seen = len_seen + 1;
            len_got  = len_out;
         end
         if (!in_ready) busy_n = busy_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int s, input int i);
      return 8'(((s * 53 + i * 29 + 7) % 251) + 1);
   endfunction

   task automatic beat(input logic [7:0] d, input bit nd, input bit sl, input bit fl);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = d; in_nodata = nd;
      in_seg_last = sl; in_frame_last = fl;
      @(posedge clk);
      #1;
      in_valid = 1'b0; in_nodata = 1'b0; in_seg_last = 1'b0; in_frame_last = 1'b0;
   endtask

   task automatic clear_log();
      @(negedge clk);
      lg_n = 0; len_seen = 0; busy_n = 0;
   endtask

   task automatic wait_len();
      while (len_seen == 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_frame(input bit wm, input int n, input int s);
      int nw, pads, tail, bad, bad_j, first_a, first_e;
      word_mode = wm;
      clear_log();
      if (n == 0) begin
         beat(8'h00, 1'b1, 1'b1, 1'b1);
      end else begin
         for (int i = 0; i < n; i++) begin
            bit last, cut;
            last = (i == n - 1);
            cut  = ((i + s) % 3) == 0;
            beat(pat(s, i), 1'b0, cut || last, last);
            // R7: zero-length segment while a byte may be held
            if (cut && !last && ((i + s) % 2) == 0) beat(8'h00, 1'b1, 1'b1, 1'b0);
         end
      end
      wait_len();
      if (wm) begin
         nw   = ((n + 1) / 2 > 30) ? (n + 1) / 2 : 30;
         pads = nw - (n + 1) / 2;
         tail = pads + (n % 2) + 1;
      end else begin
         nw   = (n > 60) ? n : 60;
         pads = nw - n;
         tail = pads + 1;
      end
      if (wm) chk(lg_n == nw, "R8", "word write count", lg_n, nw);
      else    chk(lg_n == nw, "R1", "byte write count", lg_n, nw);
      bad = 0; bad_j = -1; first_a = 0; first_e = 0;
      for (int j = 0; j < nw && j < lg_n && j < 128; j++) begin
         logic [15:0] e;
         if (wm) begin
            e[7:0]  = (2 * j < n)     ? pat(s, 2 * j)     : 8'h00;
            e[15:8] = (2 * j + 1 < n) ? pat(s, 2 * j + 1) : 8'h00;
         end else begin
            e = {8'h00, (j < n) ? pat(s, j) : 8'h00};
         end
         if (lg_d[j] !== e || lg_w[j] !== wm) begin
            if (bad == 0) begin bad_j = j; first_a = int'({lg_w[j], lg_d[j]}); first_e = int'({wm, e}); end
            bad++;
         end
      end
      if (wm) chk(bad == 0, "R3 R4 R7", $sformatf("word data n=%0d first bad idx %0d", n, bad_j), first_a, first_e);
      else    chk(bad == 0, "R6 R1", $sformatf("byte data n=%0d first bad idx %0d", n, bad_j), first_a, first_e);
      if (wm && (n % 2) == 1) begin
         int k;
         k = n / 2;
         chk(lg_d[k] === {8'h00, pat(s, n - 1)}, "R5", "flushed odd byte",
             int'(lg_d[k]), int'({8'h00, pat(s, n - 1)}));
      end
      chk(len_seen == 1 && len_got == 16'((n > 60) ? n : 60), "R2", "reported length",
          int'(len_got), (n > 60) ? n : 60);
      chk(busy_n == tail, "R9", "stall cycles", busy_n, tail);
   endtask

   initial begin
      #200000;
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R10: reset state
      chk(!wr_en && !len_valid && in_ready, "R10", "reset state",
          int'({wr_en, len_valid, in_ready}), 1);

      // R6: write follows acceptance by one cycle
      word_mode = 1'b0;
      clear_log();
      beat(8'hA5, 1'b0, 1'b0, 1'b0);
      chk(wr_en && !wr_wide && wr_data == 16'h00A5, "R6", "byte write timing",
          int'({wr_en, wr_wide, wr_data}), int'({2'b10, 16'h00A5}));
      beat(8'h00, 1'b1, 1'b1, 1'b1);
      wait_len();
      chk(len_got == 16'd60, "R2", "single byte length", int'(len_got), 60);

      for (int wm = 0; wm < 2; wm++)
         for (int n = 0; n <= 70; n++)
            run_frame(wm[0], n, n + wm * 7);

      // R10: reset while a byte is held and counters are nonzero
      word_mode = 1'b1;
      clear_log();
      beat(8'h11, 1'b0, 1'b0, 1'b0);
      beat(8'h22, 1'b0, 1'b0, 1'b0);
      beat(8'h33, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk(!wr_en && !len_valid && in_ready, "R10", "state after mid-frame reset",
          int'({wr_en, len_valid, in_ready}), 1);
      run_frame(1'b1, 5, 9);
      chk(lg_d[0] === {pat(9, 1), pat(9, 0)}, "R10", "first word after reset",
          int'(lg_d[0]), int'({pat(9, 1), pat(9, 0)}));
      chk(lg_n == 30, "R10", "write count after reset", lg_n, 30);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule